// File: doc/BRIEF.md
# System Control Register Block

This block is a word-addressed register file for system-level control settings. It decodes a 4 KiB byte window on a simple 32-bit register bus with an address, a write enable, write data, a read enable and registered read data. Storage covers only the lower half of the window: 512 words, selected by the byte offset divided by four. Any access to the upper half stores nothing, reads back zero, and pulses an error strobe.

Two kinds of access have side effects. One command offset in the unstored upper half turns certain write values into a one-cycle system reset request or shutdown request. A write there is still reported as out of range. Three status offsets always read with bits 29 and 28 set, whatever their stored contents are. Four identification words come out of reset with fixed non-zero values. Every other word resets to zero.

Top module: `sysctl_regs`

## Requirements
- R1: After reset, word 0x40 holds 0x05F20121, word 0x41 holds 0x00000002, word 0x42 holds 0x05F30121, word 0x43 holds 0x05F40121, and every other stored word holds 0. Before the first read, rd_data, reset_req, shutdown_req and range_err are all 0.
- R2: A write to a word index below 0x200 (byte offset below 0x800) stores wr_data. A read with rd_en high presents the word on rd_data one cycle after the read cycle.
- R3: A write at byte offset 0x800 or above changes no stored word. A read there returns 0.
- R4: range_err is high for exactly the one cycle after any read or write at byte offset 0x800 or above. It stays low after in-range accesses.
- R5: A write of 1 or 2 to byte offset 0xF00 raises reset_req for the single cycle after the write. No write anywhere else raises it.
- R6: A write of 3 to byte offset 0xF00 raises shutdown_req for the single cycle after the write. Any other value at that offset raises neither request.
- R7: Reads at byte offsets 0x100, 0x108 and 0x10C return the stored word OR 0x30000000. The stored word itself keeps its written bits 29:28. Word 0x41 (offset 0x104) is not forced.
- R8: Address bits 1:0 are ignored for both reads and writes.
- R9: When a read and a write to the same word happen in the same cycle, the read returns the contents from before the write.
- R10: rd_data holds its last value in cycles that follow no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 12 | Byte address within the window |
| wr_en | input | 1 | Write strobe for this cycle |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe for this cycle |
| rd_data | output | 32 | Registered read data |
| reset_req | output | 1 | One-cycle system reset request |
| shutdown_req | output | 1 | One-cycle shutdown request |
| range_err | output | 1 | One-cycle out-of-range access strobe |

## Verification
Faulty decode or storage state shows at rd_data on the cycle after the read that touches the affected word. A word index that aliases across the 0x800 boundary shows as in-range words changed by upper-half writes. The sweeps therefore read every stored word after each full-window pass, so a wrong reset value, an aliased index or a lost write shows up within one read of the word involved. Command and error faults show as a missing, extra or misplaced one-cycle pulse directly after the triggering write.

// File: rtl/sysctl_pkg.sv
// Package: shared constants for the system control register block.
// Assumes 32-bit data; word indices are byte offset divided by four.
package sysctl_pkg;

    localparam logic [31:0] FORCE_MASK = 32'h3000_0000;

    // Word index of the command offset (byte 0xF00)
    localparam int unsigned CMD_WORD = 32'h3C0;

    // Words whose reads always show the forced bits
    localparam int unsigned N_FORCED = 3;
    localparam int unsigned FORCED_WORDS [N_FORCED] = '{32'h40, 32'h42, 32'h43};

    typedef enum logic [31:0] {
        CMD_RESET_A  = 32'd1,
        CMD_RESET_B  = 32'd2,
        CMD_SHUTDOWN = 32'd3
    } cmd_code_e;

    // Reset value of a storage word
    function automatic logic [31:0] reset_value(input int unsigned idx);
        case (idx)
            32'h40:  return 32'h05F2_0121;
            32'h41:  return 32'h0000_0002;
            32'h42:  return 32'h05F3_0121;
            32'h43:  return 32'h05F4_0121;
            default: return 32'h0;
        endcase
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
// Module: address decode for the register window.
// Produces the storage index, range flag, command-offset flag and
// forced-read flag from a byte address. Purely combinational.
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned STORE_WORDS = 512,
    localparam int unsigned IDX_W      = $clog2(STORE_WORDS)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic              in_range,
    output logic              is_cmd,
    output logic              is_forced
);
    localparam int unsigned WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0]   word;
    logic [1:0]          unused_lsb;
    logic [N_FORCED-1:0] forced_hit;

    // Split the byte address into word index and ignored byte lanes
    assign word       = addr[ADDR_W-1:2];
    assign unused_lsb = addr[1:0];
    assign idx        = word[IDX_W-1:0];
    assign in_range   = 32'(word) < 32'(STORE_WORDS);
    assign is_cmd     = 32'(word) == CMD_WORD;

    // One comparator per forced offset
    generate
        for (genvar k = 0; k < int'(N_FORCED); k++) begin : g_forced
            assign forced_hit[k] = 32'(word) == FORCED_WORDS[k];
        end
    endgenerate

    assign is_forced = |forced_hit;

endmodule

// File: rtl/sysctl_store.sv
// Module: word storage with per-word reset values.
// One write port and one combinational read port. Assumes the caller
// has already qualified the write with the range check.
module sysctl_store
    import sysctl_pkg::*;
#(
    parameter int unsigned STORE_WORDS = 512,
    parameter int unsigned DATA_W      = 32,
    localparam int unsigned IDX_W      = $clog2(STORE_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rword
);
    logic [DATA_W-1:0] mem [STORE_WORDS];

    // Load identification values on reset, else store the accepted write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(STORE_WORDS); i++) begin
                mem[i] <= DATA_W'(reset_value(i));
            end
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    // Read the addressed word
    assign rword = mem[ridx];

    // R2: an accepted write lands in the addressed word
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(widx)] == $past(wdata));

endmodule

// File: rtl/sysctl_cmd.sv
// Module: command decode for the reset and shutdown requests.
// Turns an accepted write at the command offset into a one-cycle
// request pulse. Values other than the three codes are ignored.
module sysctl_cmd
    import sysctl_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              is_cmd,
    input  logic [DATA_W-1:0] wdata,
    output logic              reset_req,
    output logic              shutdown_req
);
    logic hit_reset;
    logic hit_off;

    // Match the command codes against the write data
    always_comb begin
        hit_reset = 1'b0;
        hit_off   = 1'b0;
        if (fire && is_cmd) begin
            case (32'(wdata))
                CMD_RESET_A, CMD_RESET_B: hit_reset = 1'b1;
                CMD_SHUTDOWN:             hit_off   = 1'b1;
                default:                  ;
            endcase
        end
    end

    // Register the requests as single-cycle pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_req    <= 1'b0;
            shutdown_req <= 1'b0;
        end else begin
            reset_req    <= hit_reset;
            shutdown_req <= hit_off;
        end
    end

    // R6: the two requests never coincide
    p_req_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(reset_req && shutdown_req));

    // R5: a reset request follows a write at the command offset
    p_reset_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(fire && is_cmd));

    // R6: a shutdown request follows a write of the shutdown code
    p_off_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |-> $past(fire && is_cmd && 32'(wdata) == 32'd3));

endmodule

// File: rtl/sysctl_regs.sv
// Module: system control register block, top level.
// Assumes full-word accesses; address bits 1:0 are ignored. Read data
// has one cycle of latency and holds between reads. Out-of-range
// accesses are dropped and pulse range_err.
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned STORE_WORDS = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              reset_req,
    output logic              shutdown_req,
    output logic              range_err
);
    localparam int unsigned IDX_W = $clog2(STORE_WORDS);
    localparam logic [DATA_W-1:0] MASK = DATA_W'(FORCE_MASK);

    logic [IDX_W-1:0]  idx;
    logic              in_range;
    logic              is_cmd;
    logic              is_forced;
    logic [DATA_W-1:0] rword;

    sysctl_decode #(
        .ADDR_W      (ADDR_W),
        .STORE_WORDS (STORE_WORDS)
    ) u_decode (
        .addr      (addr),
        .idx       (idx),
        .in_range  (in_range),
        .is_cmd    (is_cmd),
        .is_forced (is_forced)
    );

    sysctl_store #(
        .STORE_WORDS (STORE_WORDS),
        .DATA_W      (DATA_W)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en && in_range),
        .widx  (idx),
        .wdata (wr_data),
        .ridx  (idx),
        .rword (rword)
    );

    sysctl_cmd #(
        .DATA_W (DATA_W)
    ) u_cmd (
        .clk          (clk),
        .rst_n        (rst_n),
        .fire         (wr_en),
        .is_cmd       (is_cmd),
        .wdata        (wr_data),
        .reset_req    (reset_req),
        .shutdown_req (shutdown_req)
    );

    // Register read data with forcing and range masking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            if (!in_range)      rd_data <= '0;
            else if (is_forced) rd_data <= rword | MASK;
            else                rd_data <= rword;
        end
    end

    // Pulse the error strobe for any out-of-range access
    always_ff @(posedge clk) begin
        if (!rst_n) range_err <= 1'b0;
        else        range_err <= (rd_en || wr_en) && !in_range;
    end

    // R3: an out-of-range read returns zero
    p_oor_read_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(rd_en) && 32'($past(addr)) >= 4 * STORE_WORDS
        |-> rd_data == '0);

    // R4: the error strobe only follows an access
    p_err_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        range_err |-> $past(rd_en || wr_en));

    // R7: forced offsets always read bits 29:28 set
    p_forced_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(rd_en) && $past(is_forced)
        |-> (rd_data & MASK) == MASK);

    // R10: read data is stable after a cycle with no read
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(rd_en) |-> $stable(rd_data));

endmodule

// File: tb/sysctl_regs_tb.sv
`timescale 1ns/1ps
module sysctl_regs_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        reset_req;
    logic        shutdown_req;
    logic        range_err;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sysctl_regs u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr         (addr),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_en        (rd_en),
        .rd_data      (rd_data),
        .reset_req    (reset_req),
        .shutdown_req (shutdown_req),
        .range_err    (range_err)
    );

    function automatic logic [31:0] exp_reset(input int w);
        if (w == 'h40) return 32'h05F2_0121;
        if (w == 'h41) return 32'h0000_0002;
        if (w == 'h42) return 32'h05F3_0121;
        if (w == 'h43) return 32'h05F4_0121;
        return 32'h0;
    endfunction

    function automatic logic [31:0] forced(input int w, input logic [31:0] v);
        if (w == 'h40 || w == 'h42 || w == 'h43) return v | 32'h3000_0000;
        return v;
    endfunction

    function automatic logic [31:0] pat(input int w, input int pass);
        return (32'(w) * 32'h0001_0003) ^ (32'(pass) * 32'h9E37_79B1) ^ 32'h1234_5678;
    endfunction

    task automatic check(input logic ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One write cycle; outputs of that write are sampled at the next negedge
    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] held;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs idle after reset
        check(rd_data == 0 && !reset_req && !shutdown_req && !range_err,
              "R1 idle", {rd_data[31:3], reset_req, shutdown_req, range_err}, 32'h0);

        // R1: reset contents of every word, R4 no error in range
        for (int w = 0; w < 512; w++) begin
            bus_read(12'(w * 4));
            check(rd_data == forced(w, exp_reset(w)), "R1 reset word", rd_data, forced(w, exp_reset(w)));
            check(!range_err, "R4 in-range read", 32'(range_err), 32'h0);
        end

        // R2: fill every word, then read all back
        for (int w = 0; w < 512; w++) begin
            bus_write(12'(w * 4), pat(w, 1));
            check(!range_err && !reset_req, "R4 in-range write",
                  {30'h0, range_err, reset_req}, 32'h0);
        end
        for (int w = 0; w < 512; w++) begin
            bus_read(12'(w * 4));
            check(rd_data == forced(w, pat(w, 1)), "R2 readback", rd_data, forced(w, pat(w, 1)));
        end

        // R3/R4: sweep the upper half, skipping command codes by value
        for (int w = 512; w < 1024; w++) begin
            bus_write(12'(w * 4), 32'hFFFF_FFF0 ^ 32'(w));
            check(range_err, "R4 oor write", 32'(range_err), 32'h1);
            check(!reset_req && !shutdown_req, "R6 no request",
                  {30'h0, reset_req, shutdown_req}, 32'h0);
            bus_read(12'(w * 4));
            check(rd_data == 0, "R3 oor read", rd_data, 32'h0);
            check(range_err, "R4 oor read", 32'(range_err), 32'h1);
        end
        @(negedge clk);
        check(!range_err, "R4 single pulse", 32'(range_err), 32'h0);
        for (int w = 0; w < 512; w++) begin
            bus_read(12'(w * 4));
            check(rd_data == forced(w, pat(w, 1)), "R3 no alias", rd_data, forced(w, pat(w, 1)));
        end

        // R5/R6: command values at 0xF00
        for (int v = 0; v < 9; v++) begin
            logic [31:0] val;
            val = (v == 8) ? 32'hFFFF_FFFF : ((v == 7) ? 32'h0000_0101 : 32'(v));
            bus_write(12'hF00, val);
            check(reset_req == (val == 1 || val == 2), "R5 reset code",
                  32'(reset_req), 32'(val == 1 || val == 2));
            check(shutdown_req == (val == 3), "R6 shutdown code",
                  32'(shutdown_req), 32'(val == 3));
            check(range_err, "R4 cmd offset flagged", 32'(range_err), 32'h1);
            @(negedge clk);
            check(!reset_req && !shutdown_req, "R5 pulse width",
                  {30'h0, reset_req, shutdown_req}, 32'h0);
        end
        bus_write(12'h00C, 32'd1);
        check(!reset_req, "R5 in-range code write", 32'(reset_req), 32'h0);
        bus_write(12'hF04, 32'd2);
        check(!reset_req, "R5 neighbour offset", 32'(reset_req), 32'h0);
        bus_write(12'hF03, 32'd3);
        check(shutdown_req, "R8 cmd low bits", 32'(shutdown_req), 32'h1);

        // R7: forcing does not change stored bits
        bus_write(12'h100, 32'h0);
        bus_read(12'h100);
        check(rd_data == 32'h3000_0000, "R7 forced zero", rd_data, 32'h3000_0000);
        bus_write(12'h104, 32'h0);
        bus_read(12'h104);
        check(rd_data == 32'h0, "R7 unforced 0x104", rd_data, 32'h0);
        bus_write(12'h10C, 32'hCFFF_FFFF);
        bus_read(12'h10C);
        check(rd_data == 32'hFFFF_FFFF, "R7 forced bits", rd_data, 32'hFFFF_FFFF);

        // R8: byte lane bits ignored
        bus_write(12'h017, 32'hDEAD_0017);
        for (int b = 0; b < 4; b++) begin
            bus_read(12'h014 + 12'(b));
            check(rd_data == 32'hDEAD_0017, "R8 low bits", rd_data, 32'hDEAD_0017);
        end

        // R9: simultaneous read and write
        @(negedge clk);
        addr = 12'h014; wr_data = 32'h0BAD_F00D; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check(rd_data == 32'hDEAD_0017, "R9 old value", rd_data, 32'hDEAD_0017);
        bus_read(12'h014);
        check(rd_data == 32'h0BAD_F00D, "R9 new value", rd_data, 32'h0BAD_F00D);

        // R10: hold across idle and write-only cycles
        held = rd_data;
        repeat (3) @(negedge clk);
        bus_write(12'h014, 32'h1111_2222);
        check(rd_data == held, "R10 hold", rd_data, held);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule